// File: doc/BRIEF.md
# Register Preload and Security Lock Controller

This block looks after a small bank of state flip-flops. It covers their clearing at power-up, a hold interval after power-up, the forcing of single bits through a test path, and a one-time lock that shuts off test access. The block also keeps a small configuration image that can be read back word by word. Next to the image sits a 64-bit user signature. The non-volatile storage is modelled as ordinary flops.

A phase machine has three states. PH_RESET is held while the power-on reset input is high. The transition RESET_TO_HOLD happens on the first clock edge after reset is released. In PH_HOLD a cycle counter runs and every request is ignored. The transition HOLD_TO_RUN fires when the counter expires. PH_RUN is the working state: the bank follows its functional next-state input, and preload, readback, image writes, signature writes, lock and erase are all honoured. The RUN_STAY transition keeps the machine in PH_RUN until the next power-on reset.

Once the lock is set, preload and readback are refused, and the refusal already applies in the cycle the lock is set. A refused request gives a one-cycle error pulse and changes nothing else. The signature stays readable whatever the lock state. A full erase clears the image and the lock.

Top module: `preload_lock_ctrl`

## Requirements
- R1: While `por` is high, `state_q` is all zeros, `busy` is 1, `locked` is 0, `err` and `rb_valid` are 0, and `sig_rdata` is 0.
- R2: After `por` falls, `busy` stays 1 for exactly HOLD_CYCLES clock edges and falls on edge HOLD_CYCLES+1. While `busy` is 1, every request input has no effect: the state bank stays 0, no error pulses, no readback, and no write, lock or erase takes place.
- R3: In PH_RUN with `upd_en`=1 and `pl_req`=0, `state_q` takes `run_d` at the next edge. With `upd_en`=0 it holds.
- R4: An accepted preload sets bit `pl_idx` of `state_q` (bit 0 = LSB) to `pl_val` at the next edge. All other bits hold, and `upd_en` is ignored in that cycle.
- R5: An accepted readback request gives `rb_valid`=1 for exactly one cycle after the next edge, with `rb_data` holding the image word at `rb_addr` as it stood before that edge.
- R6: `sig_we` replaces the whole signature at the next edge. `sig_rdata` shows the stored signature at all times, both locked and unlocked.
- R7: `sec_prog` sets `locked` at the next edge, and it stays set until an erase. A preload or readback in the same cycle as `sec_prog`, or in any later locked cycle, is refused.
- R8: A refused preload or readback gives `err`=1 for exactly one cycle after the next edge, with `rb_valid`=0. A refused preload leaves `state_q` unchanged, and a refused readback leaves `rb_data` unchanged.
- R9: `erase` clears `locked` and every image word at the next edge and keeps the signature. If `erase` and `sec_prog` come in the same cycle, `locked` ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, active high, asynchronous |
| upd_en | input | 1 | Load functional next state into the bank |
| run_d | input | N_REGS | Functional next state |
| pl_req | input | 1 | Preload request |
| pl_idx | input | IDX_W | Bit index to force |
| pl_val | input | 1 | Value to force |
| cfg_we | input | 1 | Image word write |
| cfg_addr | input | ADR_W | Image write address |
| cfg_wdata | input | CFG_W | Image write data |
| rb_req | input | 1 | Readback request |
| rb_addr | input | ADR_W | Readback address |
| rb_data | output | CFG_W | Readback word |
| rb_valid | output | 1 | Readback word valid |
| sig_we | input | 1 | Signature write |
| sig_wdata | input | SIG_W | Signature write data |
| sig_rdata | output | SIG_W | Stored signature |
| sec_prog | input | 1 | Set the security lock |
| erase | input | 1 | Full erase of image and lock |
| busy | output | 1 | Reset or hold interval in progress |
| locked | output | 1 | Security lock state |
| err | output | 1 | One-cycle refusal pulse |
| state_q | output | N_REGS | State bank contents |

## Verification
If the phase machine is stuck or leaves PH_HOLD too early, `busy` falls on the wrong edge after reset release, or a request made during the hold shows up in `state_q` or `err` one edge later. A lock bit that is wrong shows on the first test request. Either `err` pulses where `rb_valid` or a changed `state_q` was expected, or the reverse, and in both cases this is visible at the edge right after the request. A bad image or signature store shows on the next readback or at once on `sig_rdata`.

// File: rtl/plc_pkg.sv
package plc_pkg;
    typedef enum logic [1:0] {
        PH_RESET = 2'd0,
        PH_HOLD  = 2'd1,
        PH_RUN   = 2'd2
    } phase_e;
endpackage

// File: rtl/plc_hold_timer.sv
module plc_hold_timer #(
    parameter int HOLD_CYCLES = 8
) (
    input  logic clk,
    input  logic por,
    input  logic en,
    output logic done
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or posedge por) begin
        if (por)      cnt <= '0;
        else if (!en) cnt <= '0;
        else          cnt <= cnt + CW'(1);
    end

    assign done = en && (cnt == CW'(HOLD_CYCLES - 1));
endmodule

// File: rtl/plc_state_bank.sv
module plc_state_bank #(
    parameter int N_REGS = 10,
    localparam int IDX_W = (N_REGS > 1) ? $clog2(N_REGS) : 1
) (
    input  logic              clk,
    input  logic              por,
    input  logic              upd,
    input  logic [N_REGS-1:0] run_d,
    input  logic              pl_go,
    input  logic [IDX_W-1:0]  pl_idx,
    input  logic              pl_val,
    output logic [N_REGS-1:0] q
);
    for (genvar i = 0; i < N_REGS; i++) begin : g_bit
        always_ff @(posedge clk or posedge por) begin
            if (por)                                   q[i] <= 1'b0;
            else if (pl_go && (pl_idx == IDX_W'(i)))   q[i] <= pl_val;
            else if (upd)                              q[i] <= run_d[i];
        end
    end
endmodule

// File: rtl/plc_nv_store.sv
module plc_nv_store #(
    parameter int CFG_WORDS = 4,
    parameter int CFG_W     = 16,
    parameter int SIG_W     = 64,
    localparam int ADR_W    = (CFG_WORDS > 1) ? $clog2(CFG_WORDS) : 1
) (
    input  logic             clk,
    input  logic             por,
    input  logic             wr,
    input  logic [ADR_W-1:0] wr_addr,
    input  logic [CFG_W-1:0] wr_data,
    input  logic [ADR_W-1:0] rd_addr,
    output logic [CFG_W-1:0] rd_word,
    input  logic             sig_wr,
    input  logic [SIG_W-1:0] sig_in,
    output logic [SIG_W-1:0] sig_out,
    input  logic             lock_set,
    input  logic             wipe,
    output logic             lock_q
);
    logic [CFG_W-1:0] image [CFG_WORDS];

    for (genvar w = 0; w < CFG_WORDS; w++) begin : g_word
        always_ff @(posedge clk or posedge por) begin
            if (por)                                 image[w] <= '0;
            else if (wipe)                           image[w] <= '0;
            else if (wr && (wr_addr == ADR_W'(w)))   image[w] <= wr_data;
        end
    end

    always_ff @(posedge clk or posedge por) begin
        if (por) begin
            sig_out <= '0;
            lock_q  <= 1'b0;
        end else begin
            if (sig_wr)        sig_out <= sig_in;
            if (lock_set)      lock_q  <= 1'b1;
            else if (wipe)     lock_q  <= 1'b0;
        end
    end

    assign rd_word = image[rd_addr];
endmodule

// File: rtl/preload_lock_ctrl.sv
module preload_lock_ctrl
    import plc_pkg::*;
#(
    parameter int N_REGS      = 10,
    parameter int HOLD_CYCLES = 8,
    parameter int CFG_WORDS   = 4,
    parameter int CFG_W       = 16,
    parameter int SIG_W       = 64,
    localparam int IDX_W      = (N_REGS > 1) ? $clog2(N_REGS) : 1,
    localparam int ADR_W      = (CFG_WORDS > 1) ? $clog2(CFG_WORDS) : 1
) (
    input  logic              clk,
    input  logic              por,
    input  logic              upd_en,
    input  logic [N_REGS-1:0] run_d,
    input  logic              pl_req,
    input  logic [IDX_W-1:0]  pl_idx,
    input  logic              pl_val,
    input  logic              cfg_we,
    input  logic [ADR_W-1:0]  cfg_addr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              rb_req,
    input  logic [ADR_W-1:0]  rb_addr,
    output logic [CFG_W-1:0]  rb_data,
    output logic              rb_valid,
    input  logic              sig_we,
    input  logic [SIG_W-1:0]  sig_wdata,
    output logic [SIG_W-1:0]  sig_rdata,
    input  logic              sec_prog,
    input  logic              erase,
    output logic              busy,
    output logic              locked,
    output logic              err,
    output logic [N_REGS-1:0] state_q
);
    phase_e phase_q, phase_d;
    logic   hold_done;
    logic   running, lock_now, pl_go, rb_go, refuse;
    logic [CFG_W-1:0] rd_word;

    // phase register
    always_ff @(posedge clk or posedge por) begin
        if (por) phase_q <= PH_RESET;
        else     phase_q <= phase_d;
    end

    // phase transitions: RESET_TO_HOLD, HOLD_TO_RUN, RUN_STAY
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_RESET: phase_d = PH_HOLD;
            PH_HOLD:  if (hold_done) phase_d = PH_RUN;
            PH_RUN:   phase_d = PH_RUN;
            default:  phase_d = PH_RESET;
        endcase
    end

    assign running  = (phase_q == PH_RUN);
    assign busy     = !running;
    assign lock_now = locked || sec_prog;
    assign pl_go    = running && pl_req && !lock_now;
    assign rb_go    = running && rb_req && !lock_now;
    assign refuse   = running && (pl_req || rb_req) && lock_now;

    // registered outputs
    always_ff @(posedge clk or posedge por) begin
        if (por) begin
            err      <= 1'b0;
            rb_valid <= 1'b0;
            rb_data  <= '0;
        end else begin
            err      <= refuse;
            rb_valid <= rb_go;
            if (rb_go) rb_data <= rd_word;
        end
    end

    plc_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
        .clk  (clk),
        .por  (por),
        .en   (phase_q == PH_HOLD),
        .done (hold_done)
    );

    plc_state_bank #(.N_REGS(N_REGS)) u_bank (
        .clk    (clk),
        .por    (por),
        .upd    (running && upd_en && !pl_req),
        .run_d  (run_d),
        .pl_go  (pl_go),
        .pl_idx (pl_idx),
        .pl_val (pl_val),
        .q      (state_q)
    );

    plc_nv_store #(
        .CFG_WORDS (CFG_WORDS),
        .CFG_W     (CFG_W),
        .SIG_W     (SIG_W)
    ) u_store (
        .clk      (clk),
        .por      (por),
        .wr       (running && cfg_we),
        .wr_addr  (cfg_addr),
        .wr_data  (cfg_wdata),
        .rd_addr  (rb_addr),
        .rd_word  (rd_word),
        .sig_wr   (running && sig_we),
        .sig_in   (sig_wdata),
        .sig_out  (sig_rdata),
        .lock_set (running && sec_prog),
        .wipe     (running && erase),
        .lock_q   (locked)
    );
endmodule

// File: rtl/plc_checker.sv
module plc_checker #(
    parameter int N_REGS = 10
) (
    input logic              clk,
    input logic              por,
    input logic              busy,
    input logic              locked,
    input logic              err,
    input logic              rb_valid,
    input logic              rb_req,
    input logic              pl_req,
    input logic              sec_prog,
    input logic              erase,
    input logic [N_REGS-1:0] state_q
);
    // R1
    bank_clear_while_busy_chk: assert property (@(posedge clk) disable iff (por)
        busy |-> (state_q == '0));

    // R2
    quiet_while_busy_chk: assert property (@(posedge clk) disable iff (por)
        busy |-> (!err && !rb_valid));

    // R5
    rb_valid_cause_chk: assert property (@(posedge clk) disable iff (por)
        rb_valid |-> $past(rb_req && !busy && !locked && !sec_prog));

    // R7
    lock_sticky_chk: assert property (@(posedge clk) disable iff (por)
        (locked && !erase) |=> locked);

    // R8
    err_cause_chk: assert property (@(posedge clk) disable iff (por)
        err |-> $past(!busy && (pl_req || rb_req) && (locked || sec_prog)));

    // R8
    err_excl_chk: assert property (@(posedge clk) disable iff (por)
        err |-> !rb_valid);

    // R8
    refused_preload_hold_chk: assert property (@(posedge clk) disable iff (por)
        (err && $past(pl_req)) |-> $stable(state_q));
endmodule

bind preload_lock_ctrl plc_checker #(.N_REGS(N_REGS)) u_chk (
    .clk      (clk),
    .por      (por),
    .busy     (busy),
    .locked   (locked),
    .err      (err),
    .rb_valid (rb_valid),
    .rb_req   (rb_req),
    .pl_req   (pl_req),
    .sec_prog (sec_prog),
    .erase    (erase),
    .state_q  (state_q)
);

// File: tb/sim_preload_lock_ctrl.sv
`timescale 1ns/1ps
module sim_preload_lock_ctrl;
    localparam int N  = 10;
    localparam int H  = 8;
    localparam int WD = 4;
    localparam int CW = 16;
    localparam int SW = 64;

    logic clk = 1'b0;
    logic por = 1'b1;
    logic upd_en, pl_req, pl_val, cfg_we, rb_req, rb_valid, sig_we;
    logic sec_prog, erase, busy, locked, err;
    logic [N-1:0]  run_d, state_q;
    logic [3:0]    pl_idx;
    logic [1:0]    cfg_addr, rb_addr;
    logic [CW-1:0] cfg_wdata, rb_data;
    logic [SW-1:0] sig_wdata, sig_rdata;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    preload_lock_ctrl #(.N_REGS(N), .HOLD_CYCLES(H), .CFG_WORDS(WD),
                        .CFG_W(CW), .SIG_W(SW)) u0 (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        upd_en = 0; run_d = '0; pl_req = 0; pl_idx = '0; pl_val = 0;
        cfg_we = 0; cfg_addr = '0; cfg_wdata = '0; rb_req = 0; rb_addr = '0;
        sig_we = 0; sig_wdata = '0; sec_prog = 0; erase = 0;
    endtask

    task automatic read_word(input logic [1:0] a, input logic [CW-1:0] exp, input string tag);
        rb_req = 1; rb_addr = a;
        step();
        rb_req = 0;
        chk({tag, " rb_valid"}, rb_valid, 1);
        chk({tag, " rb_data"}, rb_data, exp);
        step();
        chk({tag, " rb_valid drop"}, rb_valid, 0);
    endtask

    task automatic t_reset();
        int hcnt = 0;
        idle();
        por = 1;
        repeat (3) @(negedge clk);
        chk("R1 state", state_q, 0);
        chk("R1 busy", busy, 1);
        chk("R1 locked", locked, 0);
        chk("R1 sig", sig_rdata, 0);
        chk("R1 err", err, 0);
        upd_en = 1; run_d = '1; pl_req = 1; pl_idx = 4'd3; pl_val = 1;
        rb_req = 1; cfg_we = 1; cfg_wdata = 16'hFFFF; sig_we = 1; sig_wdata = '1;
        sec_prog = 1;
        por = 0;
        for (int k = 0; k < 40; k++) begin
            step();
            if (!busy) begin
                idle();
                break;
            end
            hcnt++;
            if (state_q !== '0 || err !== 0 || rb_valid !== 0 || locked !== 0)
                chk("R2 quiet during hold", {state_q, err, rb_valid, locked}, 0);
        end
        chk("R2 hold length", hcnt, H);
        chk("R2 sig untouched", sig_rdata, 0);
        chk("R2 lock untouched", locked, 0);
        chk("R2 bank untouched", state_q, 0);
        read_word(2'd0, 16'h0000, "R2 image untouched");
    endtask

    task automatic t_update();
        upd_en = 1; run_d = 10'h2A5;
        step();
        chk("R3 load A", state_q, 10'h2A5);
        run_d = 10'h15A;
        step();
        chk("R3 load B", state_q, 10'h15A);
        run_d = 10'h2A5;
        step();
        upd_en = 0; run_d = 10'h3FF;
        step();
        chk("R3 hold when disabled", state_q, 10'h2A5);
    endtask

    task automatic t_preload();
        pl_req = 1; pl_idx = 4'd0; pl_val = 0;
        step();
        chk("R4 clear bit0", state_q, 10'h2A4);
        pl_idx = 4'd9; pl_val = 0;
        step();
        chk("R4 clear bit9", state_q, 10'h0A4);
        pl_idx = 4'd1; pl_val = 1; upd_en = 1; run_d = '0;
        step();
        chk("R4 set bit1 over update", state_q, 10'h0A6);
        idle();
        step();
        chk("R4 no further change", state_q, 10'h0A6);
    endtask

    task automatic t_cfg();
        for (int a = 0; a < WD; a++) begin
            cfg_we = 1; cfg_addr = 2'(a); cfg_wdata = 16'hC0D0 + 16'(a * 17);
            step();
        end
        cfg_we = 0;
        read_word(2'd2, 16'hC0D0 + 16'd34, "R5 word2");
        read_word(2'd0, 16'hC0D0, "R5 word0");
        cfg_we = 1; cfg_addr = 2'd3; cfg_wdata = 16'h1234;
        read_word(2'd3, 16'hC0D0 + 16'd51, "R5 old value on same-cycle write");
        cfg_we = 0;
        read_word(2'd3, 16'h1234, "R5 new value");
    endtask

    task automatic t_sig();
        sig_we = 1; sig_wdata = 64'h0123_4567_89AB_CDEF;
        step();
        sig_we = 0;
        chk("R6 sig write", sig_rdata, 64'h0123_4567_89AB_CDEF);
    endtask

    task automatic t_lock();
        sec_prog = 1; pl_req = 1; pl_idx = 4'd5; pl_val = 1;
        step();
        idle();
        chk("R7 locked set", locked, 1);
        chk("R7 same-cycle preload refused err", err, 1);
        chk("R8 state unchanged", state_q, 10'h0A6);
        step();
        chk("R8 err one cycle", err, 0);
        chk("R7 sticky", locked, 1);
        rb_req = 1; rb_addr = 2'd1;
        step();
        rb_req = 0;
        chk("R8 readback refused err", err, 1);
        chk("R8 no rb_valid", rb_valid, 0);
        chk("R8 rb_data held", rb_data, 16'h1234);
        pl_req = 1; pl_idx = 4'd2; pl_val = 0; rb_req = 1;
        step();
        idle();
        chk("R8 both refused single err", err, 1);
        chk("R8 state still unchanged", state_q, 10'h0A6);
        chk("R6 sig readable locked", sig_rdata, 64'h0123_4567_89AB_CDEF);
        sig_we = 1; sig_wdata = 64'hFEED_FACE_0000_1111;
        step();
        sig_we = 0;
        chk("R6 sig write locked", sig_rdata, 64'hFEED_FACE_0000_1111);
    endtask

    task automatic t_erase();
        erase = 1;
        step();
        erase = 0;
        chk("R9 lock cleared", locked, 0);
        chk("R9 sig kept", sig_rdata, 64'hFEED_FACE_0000_1111);
        read_word(2'd3, 16'h0000, "R9 word3 cleared");
        read_word(2'd0, 16'h0000, "R9 word0 cleared");
        erase = 1; sec_prog = 1;
        step();
        idle();
        chk("R9 lock wins over erase", locked, 1);
        erase = 1;
        step();
        erase = 0;
        chk("R9 second erase unlocks", locked, 0);
        pl_req = 1; pl_idx = 4'd8; pl_val = 1;
        step();
        pl_req = 0;
        chk("R9 preload works after erase", state_q, 10'h1A6);
        chk("R9 no err after erase", err, 0);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired act=1 exp=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_update();
        t_preload();
        t_cfg();
        t_sig();
        t_lock();
        t_erase();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule